// File: doc/BRIEF.md
# Dual-Bank OUT Endpoint Packet Buffer

This block holds received data for one USB OUT endpoint. A packet receiver on the bus side marks a packet start, writes its bytes one per cycle and marks the end. The consumer then drains the packet one byte per read strobe. The consumer may be a processor doing register reads or a streaming transfer engine. Storage is one or two banks of 64 bytes, used in ping-pong order. In two-bank operation the receiver can fill one bank while the consumer drains the other.

A bank is handed back to the receiver in one of two ways. In manual release, the consumer writes a clear to the bank-ownership bit. In automatic release, the bank is freed as the final byte is read. The block presents the following for the bank at the head of the queue: its packet length, a flag showing unread bytes remain, the bank-ownership bit, and a received-packet flag with an interrupt enable. When a packet start arrives and no bank is free, the block refuses the packet. In streaming mode with automatic release, an empty packet is dropped and only recorded in a sticky flag.

Top module: `usb_out_ep_buf`

## Requirements
- R1: After reset, `bank_busy`, `rd_avail`, `rx_flag`, `irq`, `zlp_seen` and `rx_nak` are 0 and `byte_cnt` is 0.
- R2: One cycle after an accepted packet's end strobe, if no bank was queued before, `byte_cnt` equals the number of bytes written. `rx_flag`, `bank_busy` and `rd_avail` are 1. Each read strobe returns the packet bytes in arrival order on `rd_data` in the same cycle.
- R3: `irq` is `rx_flag` gated by `flag_ie`. A `flag_clr` pulse clears `rx_flag`. A new set event in the same cycle takes priority over the clear.
- R4: `rd_avail` falls once every byte of the head bank has been read. In manual mode `bank_busy` stays 1 until a `rel_clr` pulse, which frees the bank.
- R5: `rx_nak` is 1 when every configured bank holds a packet. That is two banks with `cfg_dual`=1 and one bank with `cfg_dual`=0. A second packet written behind the head one does not change `byte_cnt` and does not raise `rx_flag`.
- R6: When the head bank is freed while the other bank already holds a packet, the head moves to that bank one cycle later. `rx_flag` is set again and `byte_cnt` shows the new length.
- R7: With `cfg_auto`=1, reading the final byte of the head bank frees it and moves to the next bank with no `rel_clr`. If the next bank is full, `rx_flag` is set.
- R8: With `cfg_auto`=1 and `cfg_stream`=0, `rel_clr` has no effect while the head bank still has unread bytes.
- R9: With `cfg_auto`=1 and `cfg_stream`=1, a zero-length packet takes no bank and does not set `rx_flag`. It sets `zlp_seen`, which stays 1 until a `zlp_clr` pulse.
- R10: With `cfg_auto`=1 and `cfg_stream`=1, `rel_clr` frees a head bank that has only been partly read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dual | input | 1 | 1: two banks, 0: one bank |
| cfg_auto | input | 1 | 1: free a bank on its final byte read |
| cfg_stream | input | 1 | 1: consumer is a stream engine |
| rx_sop | input | 1 | Packet start strobe from the receiver |
| rx_wr | input | 1 | Byte write strobe |
| rx_data | input | 8 | Byte to store |
| rx_eop | input | 1 | Packet end strobe |
| rx_nak | output | 1 | No free bank; a packet started now is refused |
| rd_strb | input | 1 | Consumer byte read strobe |
| rd_data | output | 8 | Byte returned during the read strobe, 0 when nothing is unread |
| rel_clr | input | 1 | Clear of the bank-ownership bit (release request) |
| flag_clr | input | 1 | Clears the received-packet flag |
| flag_ie | input | 1 | Interrupt enable for the received-packet flag |
| zlp_clr | input | 1 | Clears the zero-length-seen flag |
| byte_cnt | output | 7 | Length of the packet in the head bank |
| rd_avail | output | 1 | Head bank still has unread bytes |
| bank_busy | output | 1 | Bank-ownership bit: head bank belongs to the consumer |
| rx_flag | output | 1 | Received-packet flag |
| irq | output | 1 | Interrupt request |
| zlp_seen | output | 1 | Sticky zero-length packet flag |

## Verification
The hardest state to reach is the head change that happens while the other bank is already full. In that case the release must hand over the queued packet and raise the flag again in a single cycle. The bench reaches it by writing two packets back to back before reading anything, so the receiver sees a refusal. It then drains the first bank and frees it, once by `rel_clr` and once by the automatic final-byte release. The partly read stream-mode release is reached the same way, by abandoning a packet halfway through its bytes and comparing against the later queued data.

// File: rtl/oep_pkg.sv
// Shared types for the OUT endpoint buffer.
// Assumes a fixed two-bank storage; single-bank use leaves bank 1 idle.
package oep_pkg;
    localparam int NBANK = 2;

    typedef struct packed {
        logic dual;
        logic auto_rel;
        logic stream;
    } oep_cfg_t;
endpackage

// File: rtl/oep_bank_ram.sv
// Byte storage for both banks: one write port, one asynchronous read port.
// Assumes the writer never targets the bank being read (ping-pong use).
module oep_bank_ram #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_q
);
    logic [7:0] bank_q [oep_pkg::NBANK];

    for (genvar b = 0; b < oep_pkg::NBANK; b++) begin : g_bank
        logic [7:0] mem [DEPTH];

        // Store a byte when the write targets this bank.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == b[0])) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign bank_q[b] = mem[rd_addr];
    end

    assign rd_q = bank_q[rd_bank];
endmodule

// File: rtl/oep_fill.sv
// Receive side: accepts a packet into the free bank, counts its bytes and
// reports commit or zero-length drop at the packet end.
// Assumes rx_sop, rx_wr and rx_eop arrive in separate cycles, in that order.
module oep_fill
    import oep_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  oep_cfg_t      cfg,
    input  logic          bank_full,
    input  logic          rx_sop,
    input  logic          rx_wr,
    input  logic          rx_eop,
    output logic          wr_en,
    output logic          wr_bank,
    output logic [AW-1:0] wr_addr,
    output logic          commit,
    output logic [CW-1:0] commit_len,
    output logic          zlp_hit
);
    logic          in_pkt;
    logic [CW-1:0] wcnt;
    logic          eop_hit;
    logic          zlp_filt;

    assign wr_en      = in_pkt && rx_wr && (wcnt < CW'(DEPTH));
    assign wr_addr    = wcnt[AW-1:0];
    assign eop_hit    = in_pkt && rx_eop;
    assign zlp_filt   = cfg.stream && cfg.auto_rel && (wcnt == '0);
    assign commit     = eop_hit && !zlp_filt;
    assign zlp_hit    = eop_hit && zlp_filt;
    assign commit_len = wcnt;

    // Track the packet in progress and the byte position inside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt <= 1'b0;
            wcnt   <= '0;
        end else if (rx_sop) begin
            in_pkt <= !bank_full;
            wcnt   <= '0;
        end else begin
            if (wr_en) begin
                wcnt <= wcnt + CW'(1);
            end
            if (eop_hit) begin
                in_pkt <= 1'b0;
            end
        end
    end

    // Advance the fill bank after each committed packet in two-bank use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bank <= 1'b0;
        end else if (commit && cfg.dual) begin
            wr_bank <= !wr_bank;
        end
    end
endmodule

// File: rtl/oep_track.sv
// Consumer side: bank occupancy, head bank pointer, read position,
// release decision and the received / zero-length flags.
// Assumes configuration inputs only change while no bank is occupied.
module oep_track
    import oep_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  oep_cfg_t      cfg,
    input  logic          commit,
    input  logic          commit_bank,
    input  logic [CW-1:0] commit_len,
    input  logic          zlp_hit,
    input  logic          rd_strb,
    input  logic          rel_clr,
    input  logic          flag_clr,
    input  logic          flag_ie,
    input  logic          zlp_clr,
    output logic          rd_bank,
    output logic [AW-1:0] rd_addr,
    output logic          rd_fire,
    output logic          bank_full,
    output logic [CW-1:0] byte_cnt,
    output logic          rd_avail,
    output logic          bank_busy,
    output logic          rx_flag,
    output logic          irq,
    output logic          zlp_seen
);
    logic [1:0]    occ;
    logic [1:0]    occ_next;
    logic [CW-1:0] rd_idx;
    logic [CW-1:0] len_q [NBANK];
    logic [CW-1:0] cur_len;
    logic          last_rd;
    logic          rel_ok;
    logic          release_now;
    logic          flag_set;

    assign cur_len   = len_q[rd_bank];
    assign bank_busy = (occ != 2'd0);
    assign rd_avail  = bank_busy && (rd_idx < cur_len);
    assign rd_fire   = rd_strb && rd_avail;
    assign last_rd   = rd_fire && (rd_idx == cur_len - CW'(1));
    assign rd_addr   = rd_idx[AW-1:0];
    assign byte_cnt  = bank_busy ? cur_len : '0;
    assign bank_full = occ >= (cfg.dual ? 2'd2 : 2'd1);

    // Release request: processor auto mode only frees an already empty bank.
    always_comb begin
        if (cfg.auto_rel && !cfg.stream) begin
            rel_ok = rel_clr && bank_busy && !rd_avail;
        end else begin
            rel_ok = rel_clr && bank_busy;
        end
    end

    assign release_now = (cfg.auto_rel && last_rd) || rel_ok;
    assign occ_next    = occ + {1'b0, commit} - {1'b0, release_now};
    assign flag_set    = (commit && (occ == 2'd0)) ||
                         (release_now && (occ_next != 2'd0));

    // Count occupied banks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= 2'd0;
        end else begin
            occ <= occ_next;
        end
    end

    // Record each committed packet length in its bank.
    for (genvar b = 0; b < NBANK; b++) begin : g_len
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                len_q[b] <= '0;
            end else if (commit && (commit_bank == b[0])) begin
                len_q[b] <= commit_len;
            end
        end
    end

    // Move the read position and the head bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx  <= '0;
            rd_bank <= 1'b0;
        end else if (release_now) begin
            rd_idx <= '0;
            if (cfg.dual) begin
                rd_bank <= !rd_bank;
            end
        end else if (rd_fire) begin
            rd_idx <= rd_idx + CW'(1);
        end
    end

    // Received-packet flag: a set event beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_flag <= 1'b0;
        end else if (flag_set) begin
            rx_flag <= 1'b1;
        end else if (flag_clr) begin
            rx_flag <= 1'b0;
        end
    end

    // Sticky zero-length-packet flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zlp_seen <= 1'b0;
        end else if (zlp_hit) begin
            zlp_seen <= 1'b1;
        end else if (zlp_clr) begin
            zlp_seen <= 1'b0;
        end
    end

    assign irq = rx_flag && flag_ie;
endmodule

// File: rtl/usb_out_ep_buf.sv
// OUT endpoint buffer top: connects fill logic, bank tracker and storage.
// Assumes the receiver honours rx_nak at packet start.
module usb_out_ep_buf
    import oep_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_dual,
    input  logic          cfg_auto,
    input  logic          cfg_stream,
    input  logic          rx_sop,
    input  logic          rx_wr,
    input  logic [7:0]    rx_data,
    input  logic          rx_eop,
    output logic          rx_nak,
    input  logic          rd_strb,
    output logic [7:0]    rd_data,
    input  logic          rel_clr,
    input  logic          flag_clr,
    input  logic          flag_ie,
    input  logic          zlp_clr,
    output logic [CW-1:0] byte_cnt,
    output logic          rd_avail,
    output logic          bank_busy,
    output logic          rx_flag,
    output logic          irq,
    output logic          zlp_seen
);
    oep_cfg_t      cfg;
    logic          bank_full;
    logic          wr_en;
    logic          wr_bank;
    logic [AW-1:0] wr_addr;
    logic          commit;
    logic [CW-1:0] commit_len;
    logic          zlp_hit;
    logic          rd_bank;
    logic [AW-1:0] rd_addr;
    logic          rd_fire;
    logic [7:0]    ram_q;

    assign cfg = '{dual: cfg_dual, auto_rel: cfg_auto, stream: cfg_stream};

    oep_fill #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .bank_full  (bank_full),
        .rx_sop     (rx_sop),
        .rx_wr      (rx_wr),
        .rx_eop     (rx_eop),
        .wr_en      (wr_en),
        .wr_bank    (wr_bank),
        .wr_addr    (wr_addr),
        .commit     (commit),
        .commit_len (commit_len),
        .zlp_hit    (zlp_hit)
    );

    oep_track #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg),
        .commit      (commit),
        .commit_bank (wr_bank),
        .commit_len  (commit_len),
        .zlp_hit     (zlp_hit),
        .rd_strb     (rd_strb),
        .rel_clr     (rel_clr),
        .flag_clr    (flag_clr),
        .flag_ie     (flag_ie),
        .zlp_clr     (zlp_clr),
        .rd_bank     (rd_bank),
        .rd_addr     (rd_addr),
        .rd_fire     (rd_fire),
        .bank_full   (bank_full),
        .byte_cnt    (byte_cnt),
        .rd_avail    (rd_avail),
        .bank_busy   (bank_busy),
        .rx_flag     (rx_flag),
        .irq         (irq),
        .zlp_seen    (zlp_seen)
    );

    oep_bank_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr),
        .wr_data (rx_data),
        .rd_bank (rd_bank),
        .rd_addr (rd_addr),
        .rd_q    (ram_q)
    );

    assign rx_nak  = bank_full;
    assign rd_data = rd_fire ? ram_q : 8'h00;
endmodule

// File: rtl/oep_chk.sv
// Property checker for the OUT endpoint buffer, bound to the top module.
// Assumes the reset is held low for at least one clock edge at start.
module oep_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_auto,
    input logic          cfg_stream,
    input logic          rd_strb,
    input logic          rel_clr,
    input logic          flag_clr,
    input logic          zlp_clr,
    input logic          rx_nak,
    input logic [CW-1:0] byte_cnt,
    input logic          rd_avail,
    input logic          bank_busy,
    input logic          rx_flag,
    input logic          zlp_seen
);
    // R4
    avail_needs_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_avail |-> bank_busy);

    // R9
    zlp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zlp_seen && !zlp_clr) |=> zlp_seen);

    // R8
    auto_clr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto && !cfg_stream && rel_clr && rd_avail && !rd_strb) |=> bank_busy);

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && !flag_clr) |=> rx_flag);

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= CW'(DEPTH));

    // R5
    nak_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_busy |-> !rx_nak);
endmodule

bind usb_out_ep_buf oep_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_auto   (cfg_auto),
    .cfg_stream (cfg_stream),
    .rd_strb    (rd_strb),
    .rel_clr    (rel_clr),
    .flag_clr   (flag_clr),
    .zlp_clr    (zlp_clr),
    .rx_nak     (rx_nak),
    .byte_cnt   (byte_cnt),
    .rd_avail   (rd_avail),
    .bank_busy  (bank_busy),
    .rx_flag    (rx_flag),
    .zlp_seen   (zlp_seen)
);

// File: tb/usb_out_ep_buf_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the packet driver queues expected bytes, the reader pops
// and compares them against rd_data during each read strobe.
module usb_out_ep_buf_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_dual = 1'b1, cfg_auto = 1'b0, cfg_stream = 1'b0;
    logic       rx_sop = 1'b0, rx_wr = 1'b0, rx_eop = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rd_strb = 1'b0, rel_clr = 1'b0, flag_clr = 1'b0;
    logic       flag_ie = 1'b1, zlp_clr = 1'b0;
    logic       rx_nak, rd_avail, bank_busy, rx_flag, irq, zlp_seen;
    logic [7:0] rd_data;
    logic [6:0] byte_cnt;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q [$];

    always #2.5 clk = ~clk;

    usb_out_ep_buf u_usb_out_ep_buf (
        .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_auto(cfg_auto),
        .cfg_stream(cfg_stream), .rx_sop(rx_sop), .rx_wr(rx_wr),
        .rx_data(rx_data), .rx_eop(rx_eop), .rx_nak(rx_nak),
        .rd_strb(rd_strb), .rd_data(rd_data), .rel_clr(rel_clr),
        .flag_clr(flag_clr), .flag_ie(flag_ie), .zlp_clr(zlp_clr),
        .byte_cnt(byte_cnt), .rd_avail(rd_avail), .bank_busy(bank_busy),
        .rx_flag(rx_flag), .irq(irq), .zlp_seen(zlp_seen)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one packet of n bytes; queues the bytes as expected items.
    task automatic send_pkt(int n, int seed);
        @(negedge clk) rx_sop = 1'b1;
        @(negedge clk) rx_sop = 1'b0;
        for (int i = 0; i < n; i++) begin
            rx_wr   = 1'b1;
            rx_data = 8'((seed + i * 7) & 255);
            exp_q.push_back(rx_data);
            @(negedge clk);
        end
        rx_wr  = 1'b0;
        rx_eop = 1'b1;
        @(negedge clk) rx_eop = 1'b0;
    endtask

    // Monitor: reads n bytes, popping and comparing each one.
    task automatic read_bytes(int n, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) rd_strb = 1'b1;
            #1;
            chk(req, int'(rd_data), int'(exp_q.pop_front()));
        end
        @(negedge clk) rd_strb = 1'b0;
    endtask

    task automatic do_rel();
        @(negedge clk) rel_clr = 1'b1;
        @(negedge clk) rel_clr = 1'b0;
    endtask

    task automatic do_fclr();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", bank_busy, 0);
        chk("R1 avail", rd_avail, 0);
        chk("R1 flag", rx_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 zlp", zlp_seen, 0);
        chk("R1 nak", rx_nak, 0);
        chk("R1 cnt", byte_cnt, 0);
        @(negedge clk) rst_n = 1'b1;

        // Manual release, two banks
        send_pkt(5, 16);
        chk("R2 cnt", byte_cnt, 5);
        chk("R2 flag", rx_flag, 1);
        chk("R2 busy", bank_busy, 1);
        chk("R2 avail", rd_avail, 1);
        chk("R3 irq", irq, 1);
        do_fclr();
        chk("R3 flag cleared", rx_flag, 0);
        chk("R3 irq cleared", irq, 0);
        send_pkt(3, 100);
        chk("R5 no flag behind head", rx_flag, 0);
        chk("R5 head count kept", byte_cnt, 5);
        chk("R5 nak both full", rx_nak, 1);
        read_bytes(5, "R2 data");
        chk("R4 avail drops", rd_avail, 0);
        chk("R4 still owned", bank_busy, 1);
        do_rel();
        chk("R6 flag again", rx_flag, 1);
        chk("R6 next count", byte_cnt, 3);
        chk("R6 avail", rd_avail, 1);
        do_fclr();
        read_bytes(3, "R6 data");
        do_rel();
        chk("R4 freed", bank_busy, 0);
        chk("R5 nak clear", rx_nak, 0);

        // Single bank
        cfg_dual = 1'b0;
        send_pkt(4, 40);
        chk("R5 nak one bank", rx_nak, 1);
        do_fclr();
        read_bytes(4, "R2 single data");
        do_rel();
        chk("R5 single freed", rx_nak, 0);

        // Automatic release, processor access
        cfg_dual = 1'b1;
        cfg_auto = 1'b1;
        send_pkt(6, 200);
        send_pkt(2, 77);
        do_fclr();
        do_rel();
        chk("R8 clr ignored busy", bank_busy, 1);
        chk("R8 clr ignored cnt", byte_cnt, 6);
        chk("R8 clr ignored avail", rd_avail, 1);
        read_bytes(6, "R7 data");
        chk("R7 switched cnt", byte_cnt, 2);
        chk("R7 flag again", rx_flag, 1);
        @(negedge clk) flag_ie = 1'b0;
        #1 chk("R3 irq gated", irq, 0);
        flag_ie = 1'b1;
        read_bytes(2, "R7 data2");
        chk("R7 auto freed", bank_busy, 0);
        do_fclr();

        // Streaming with automatic release
        cfg_stream = 1'b1;
        send_pkt(0, 0);
        chk("R9 zlp set", zlp_seen, 1);
        chk("R9 no bank", bank_busy, 0);
        chk("R9 no flag", rx_flag, 0);
        send_pkt(4, 9);
        do_fclr();
        read_bytes(2, "R10 data");
        do_rel();
        chk("R10 partial freed", bank_busy, 0);
        chk("R10 nak clear", rx_nak, 0);
        void'(exp_q.pop_front());
        void'(exp_q.pop_front());
        chk("R9 sticky", zlp_seen, 1);
        @(negedge clk) zlp_clr = 1'b1;
        @(negedge clk) zlp_clr = 1'b0;
        chk("R9 cleared", zlp_seen, 0);

        summary();
    end
endmodule